// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block sits beside the byte-wide receive path of an Ethernet MAC and turns what happens during a frame into per-frame error flags. While a frame is in progress it watches a received-byte strobe, the PHY receive-error line, a FIFO-full indication and a FIFO parity-fault indication. It keeps a running byte count and a sticky record of each fault. When the frame ends it reads two more inputs: the verdict of an external CRC checker and the count of trailing bits that did not fill a whole byte. It then emits one pulse per error class.

Frame boundaries come from a single frame-active level. A frame starts on the first cycle that level is high after being low. It ends on the first cycle it is low after being high. The CRC verdict, the dribble-bit count and both mode controls are sampled in that end cycle. All flags appear together, for exactly one cycle, on the following clock. The CRC engine, the FIFO and any register access sit outside this block.

Top module: `rx_err_classifier`

## Requirements
- R1: An alignment flag pulses when both of these hold in the end cycle: `rx_drib_bits` is nonzero, and `rx_crc_good` is low. This applies only while `cfg_ign_crc` is low.
- R2: While `cfg_ign_crc` is high in the end cycle, the alignment flag stays low. The CRC flag is still reported as R3 describes.
- R3: The CRC flag pulses when `rx_crc_good` is low in the end cycle, or when `phy_rx_err` was high in any cycle of the frame. `phy_rx_err` while no frame is active has no effect.
- R4: The overflow flag pulses when some cycle of the frame had `rx_byte_vld` and `fifo_full` high together. `fifo_full` with no byte strobe does not count.
- R5: The long-frame flag pulses when the frame carried more than 1518 byte strobes and `cfg_long_en` is low in the end cycle. A frame of exactly 1518 bytes does not raise it.
- R6: The parity flag pulses when `fifo_par_err` was high in any cycle of the frame.
- R7: All flags are low except in the single cycle after a frame's end cycle. Fault records are cleared at each frame start, so faults from one frame never reach the next.
- R8: The byte count saturates at its maximum instead of wrapping. A frame of more than 65536 bytes still raises the long-frame flag.
- R9: During and right after reset, all five flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_act | input | 1 | High while a frame is being received |
| rx_byte_vld | input | 1 | One received byte this cycle |
| rx_drib_bits | input | 3 | Trailing bits beyond a whole byte, sampled in the end cycle |
| rx_crc_good | input | 1 | External CRC verdict, sampled in the end cycle |
| phy_rx_err | input | 1 | PHY receive-error line |
| fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| fifo_par_err | input | 1 | Receive FIFO parity fault |
| cfg_ign_crc | input | 1 | Ignore-CRC mode, sampled in the end cycle |
| cfg_long_en | input | 1 | Allow long frames, sampled in the end cycle |
| err_align | output | 1 | Alignment error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_ovf | output | 1 | FIFO overflow pulse |
| err_long | output | 1 | Long-frame error pulse |
| err_par | output | 1 | FIFO parity error pulse |

## Verification
The bench drives frames of exactly 1518 and 1519 bytes. An off-by-one limit would flag the first or miss the second. It also drives a frame of 70000 bytes, where a counter that wraps would fall back under the limit and lose the long-frame flag. A faulty frame followed at once by a clean one shows whether the fault records are really cleared at frame start. Receive errors and FIFO faults are also driven between frames and while the byte strobe is low, which exposes a design that accumulates outside the frame or ignores the strobe. Dribble bits are tried with a good CRC, with a bad CRC, and with ignore-CRC mode on, to catch an alignment flag that ignores the CRC or a mode that also hides the CRC flag.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  localparam int unsigned FLAG_CNT = 5;

  typedef struct packed {
    logic align;
    logic crc;
    logic ovf;
    logic lng;
    logic par;
  } rx_flags_t;

  // sticky fault record index map
  localparam int unsigned ST_RXER = 0;
  localparam int unsigned ST_OVF  = 1;
  localparam int unsigned ST_PAR  = 2;
  localparam int unsigned ST_CNT  = 3;

endpackage

// File: rtl/rxc_frame_edges.sv
module rxc_frame_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_act,
  output logic act_q,
  output logic start_evt,
  output logic end_evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= frame_act;
  end

  assign start_evt = frame_act & ~act_q;
  assign end_evt   = act_q & ~frame_act;
endmodule

// File: rtl/rxc_sticky.sv
module rxc_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_evt,
  input  logic         active,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] rec_q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          rec_q[g] <= 1'b0;
      else if (start_evt)  rec_q[g] <= set_i[g];
      else if (active)     rec_q[g] <= rec_q[g] | set_i[g];
    end
  end
endmodule

// File: rtl/rxc_len_counter.sv
module rxc_len_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             active,
  input  logic             byte_vld,
  output logic [CNT_W-1:0] count_q,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign sat_o = (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (start_evt)
      count_q <= {{(CNT_W-1){1'b0}}, byte_vld};
    else if (active && byte_vld && !sat_o)
      count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/rx_err_classifier.sv
module rx_err_classifier #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned DRIB_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_frame_act,
  input  logic              rx_byte_vld,
  input  logic [DRIB_W-1:0] rx_drib_bits,
  input  logic              rx_crc_good,
  input  logic              phy_rx_err,
  input  logic              fifo_full,
  input  logic              fifo_par_err,
  input  logic              cfg_ign_crc,
  input  logic              cfg_long_en,
  output logic              err_align,
  output logic              err_crc,
  output logic              err_ovf,
  output logic              err_long,
  output logic              err_par
);
  import rxc_pkg::*;

  localparam logic [CNT_W-1:0] LEN_LIMIT = CNT_W'(MAX_LEN);

  // named internal events for the checker
  logic act_q, start_evt, end_evt;
  logic [ST_CNT-1:0] fault_set, fault_rec;
  logic [CNT_W-1:0] byte_cnt;
  logic cnt_sat;
  rx_flags_t flags_d, flags_q;

  function automatic logic over_limit(input logic [CNT_W-1:0] cnt);
    return cnt > LEN_LIMIT;
  endfunction

  function automatic rx_flags_t classify(
    input logic              crc_good,
    input logic [DRIB_W-1:0] drib,
    input logic              ign_crc,
    input logic              long_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [ST_CNT-1:0] rec
  );
    rx_flags_t f;
    f.align = (drib != '0) && !crc_good && !ign_crc;
    f.crc   = !crc_good || rec[ST_RXER];
    f.ovf   = rec[ST_OVF];
    f.lng   = over_limit(cnt) && !long_en;
    f.par   = rec[ST_PAR];
    return f;
  endfunction

  rxc_frame_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_act (rx_frame_act),
    .act_q     (act_q),
    .start_evt (start_evt),
    .end_evt   (end_evt)
  );

  assign fault_set[ST_RXER] = phy_rx_err;
  assign fault_set[ST_OVF]  = rx_byte_vld & fifo_full;
  assign fault_set[ST_PAR]  = fifo_par_err;

  rxc_sticky #(.N(ST_CNT)) u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .active    (rx_frame_act),
    .set_i     (fault_set),
    .rec_q     (fault_rec)
  );

  rxc_len_counter #(.CNT_W(CNT_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .active    (rx_frame_act),
    .byte_vld  (rx_byte_vld),
    .count_q   (byte_cnt),
    .sat_o     (cnt_sat)
  );

  always_comb begin
    flags_d = '0;
    if (end_evt)
      flags_d = classify(rx_crc_good, rx_drib_bits, cfg_ign_crc,
                         cfg_long_en, byte_cnt, fault_rec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign err_align = flags_q.align;
  assign err_crc   = flags_q.crc;
  assign err_ovf   = flags_q.ovf;
  assign err_long  = flags_q.lng;
  assign err_par   = flags_q.par;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_frame_act,
  input logic rx_crc_good,
  input logic cfg_ign_crc,
  input logic cfg_long_en,
  input logic act_q,
  input logic cnt_sat,
  input logic err_align,
  input logic err_crc,
  input logic err_ovf,
  input logic err_long,
  input logic err_par
);
  logic any_flag;
  assign any_flag = err_align | err_crc | err_ovf | err_long | err_par;

  p_align_implies_crc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> err_crc);

  p_ignore_hides_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> !$past(cfg_ign_crc));

  p_bad_crc_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act_q) && !$past(rx_frame_act) && !$past(rx_crc_good)) |-> err_crc);

  p_long_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_long |-> !$past(cfg_long_en));

  p_flags_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |-> ($past(act_q) && !$past(rx_frame_act)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |=> !any_flag);

  p_sat_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sat && rx_frame_act && !$rose(rx_frame_act)) |=> (cnt_sat || $rose(rx_frame_act)));
endmodule

bind rx_err_classifier rxc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_frame_act (rx_frame_act),
  .rx_crc_good  (rx_crc_good),
  .cfg_ign_crc  (cfg_ign_crc),
  .cfg_long_en  (cfg_long_en),
  .act_q        (act_q),
  .cnt_sat      (cnt_sat),
  .err_align    (err_align),
  .err_crc      (err_crc),
  .err_ovf      (err_ovf),
  .err_long     (err_long),
  .err_par      (err_par)
);

// File: tb/rx_err_classifier_test.sv
`timescale 1ns/1ps
module rx_err_classifier_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_frame_act = 0, rx_byte_vld = 0, rx_crc_good = 1;
  logic [2:0] rx_drib_bits = 0;
  logic phy_rx_err = 0, fifo_full = 0, fifo_par_err = 0;
  logic cfg_ign_crc = 0, cfg_long_en = 0;
  logic err_align, err_crc, err_ovf, err_long, err_par;

  int checks = 0;
  int errors = 0;
  bit compare_on = 0;

  always #4 clk = ~clk;

  rx_err_classifier uut (
    .clk(clk), .rst_n(rst_n), .rx_frame_act(rx_frame_act), .rx_byte_vld(rx_byte_vld),
    .rx_drib_bits(rx_drib_bits), .rx_crc_good(rx_crc_good), .phy_rx_err(phy_rx_err),
    .fifo_full(fifo_full), .fifo_par_err(fifo_par_err), .cfg_ign_crc(cfg_ign_crc),
    .cfg_long_en(cfg_long_en), .err_align(err_align), .err_crc(err_crc),
    .err_ovf(err_ovf), .err_long(err_long), .err_par(err_par)
  );

  // behavioural reference model
  bit in_frame = 0;
  int nbytes_seen = 0;
  bit saw_rxer = 0, saw_ovf = 0, saw_par = 0;
  bit e_align = 0, e_crc = 0, e_ovf = 0, e_long = 0, e_par = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      in_frame = 0; nbytes_seen = 0; saw_rxer = 0; saw_ovf = 0; saw_par = 0;
      e_align = 0; e_crc = 0; e_ovf = 0; e_long = 0; e_par = 0;
    end else begin
      e_align = 0; e_crc = 0; e_ovf = 0; e_long = 0; e_par = 0;
      if (in_frame && !rx_frame_act) begin
        e_align = (rx_drib_bits != 0) && !rx_crc_good && !cfg_ign_crc;
        e_crc   = !rx_crc_good || saw_rxer;
        e_ovf   = saw_ovf;
        e_long  = (nbytes_seen > 1518) && !cfg_long_en;
        e_par   = saw_par;
      end
      if (rx_frame_act && !in_frame) begin
        nbytes_seen = 0; saw_rxer = 0; saw_ovf = 0; saw_par = 0;
      end
      if (rx_frame_act) begin
        if (rx_byte_vld) nbytes_seen++;
        if (phy_rx_err) saw_rxer = 1;
        if (rx_byte_vld && fifo_full) saw_ovf = 1;
        if (fifo_par_err) saw_par = 1;
      end
      in_frame = rx_frame_act;
    end
  end

  task automatic check1(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      check1("R1 R2 align (R7 timing)", err_align, e_align);
      check1("R3 crc (R7 timing)", err_crc, e_crc);
      check1("R4 overflow (R7 timing)", err_ovf, e_ovf);
      check1("R5 R8 long (R7 timing)", err_long, e_long);
      check1("R6 parity (R7 timing)", err_par, e_par);
    end
  end

  task automatic run_frame(input int nb, input int drib, input bit good_crc,
                           input int rxer_at, input int full_at, input bit full_nobyte,
                           input int par_at, input bit ign, input bit len_en);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rx_frame_act = 1;
      rx_byte_vld  = !(full_nobyte && i == full_at);
      phy_rx_err   = (i == rxer_at);
      fifo_full    = (i == full_at);
      fifo_par_err = (i == par_at);
    end
    @(negedge clk);
    rx_frame_act = 0; rx_byte_vld = 0; phy_rx_err = 0; fifo_full = 0; fifo_par_err = 0;
    rx_drib_bits = 3'(drib); rx_crc_good = good_crc; cfg_ign_crc = ign; cfg_long_en = len_en;
    @(negedge clk);
    rx_drib_bits = 0; rx_crc_good = 1; cfg_ign_crc = 0; cfg_long_en = 0;
    repeat (3) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: flags low during reset
    check1("R9 reset align", err_align, 0);
    check1("R9 reset crc", err_crc, 0);
    check1("R9 reset ovf", err_ovf, 0);
    check1("R9 reset long", err_long, 0);
    check1("R9 reset par", err_par, 0);
    rst_n = 1;
    compare_on = 1;
    @(negedge clk);
    run_frame(64, 0, 1, -1, -1, 0, -1, 0, 0);     // clean
    run_frame(64, 3, 0, -1, -1, 0, -1, 0, 0);     // R1 align + crc
    run_frame(64, 5, 1, -1, -1, 0, -1, 0, 0);     // R1 dribble, good crc: none
    run_frame(64, 2, 0, -1, -1, 0, -1, 1, 0);     // R2 ignore: crc only
    run_frame(64, 0, 1, 30, -1, 0, -1, 0, 0);     // R3 phy error mid-frame
    run_frame(64, 0, 1, -1, 10, 0, -1, 0, 0);     // R4 overflow
    run_frame(64, 0, 1, -1, 10, 1, -1, 0, 0);     // R4 full without byte: none
    run_frame(64, 0, 1, -1, -1, 0, 63, 0, 0);     // R6 parity on last byte
    run_frame(64, 0, 1, -1, -1, 0, -1, 0, 0);     // R7 cleared after faults
    // faults between frames are ignored (R3, R4, R6)
    @(negedge clk); phy_rx_err = 1; fifo_full = 1; rx_byte_vld = 1; fifo_par_err = 1;
    @(negedge clk); phy_rx_err = 0; fifo_full = 0; rx_byte_vld = 0; fifo_par_err = 0;
    run_frame(20, 0, 1, -1, -1, 0, -1, 0, 0);
    run_frame(1518, 0, 1, -1, -1, 0, -1, 0, 0);   // R5 boundary: not long
    run_frame(1519, 0, 1, -1, -1, 0, -1, 0, 0);   // R5 long
    run_frame(1519, 0, 1, -1, -1, 0, -1, 0, 1);   // R5 long enabled
    run_frame(1, 7, 0, 0, 0, 0, 0, 0, 0);         // one-byte frame, all faults
    run_frame(70000, 0, 1, -1, -1, 0, -1, 0, 0);  // R8 saturation
    run_frame(10, 0, 1, -1, -1, 0, -1, 0, 0);     // R7 back to clean
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule